// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer arithmetic stage of a small load-store RISC core. It accepts one operation per cycle: an opcode, a first operand, a second operand taken either from a register value or from a zero-extended immediate field, a set-flags request and the current condition flags. One clock edge later it presents the result, a write enable for the destination register and the next value of the status word. The status word carries the negative, zero, carry and overflow flags in its four most significant bits.

The supported operations are add, add with carry-in, subtract, subtract with borrow, reverse subtract, copy, inverted copy, compare and compare-by-addition. Compare and compare-by-addition never write a destination, but they always update the flags. Every other operation writes a destination and touches the flags only when the set-flags input is high. The datapath width is a parameter. The core uses it at 32 bits.

Top module: `alu_nzcv_top`

## Requirements
- R1: Opcode 0 (add) writes op1 + op2. Opcode 1 (add with carry) writes op1 + op2 + C, where C is flags_i[1]. Results wrap modulo 2^WIDTH.
- R2: Opcode 2 (subtract) writes op1 - op2. Opcode 3 (subtract with borrow) writes op1 - op2 - (1 - C). Opcode 4 (reverse subtract) writes op2 - op1.
- R3: Opcode 5 (copy) writes op2 and opcode 6 (inverted copy) writes ~op2. When use_imm_i is 1, op2 is imm_i zero-extended and reg_b_i is ignored. Otherwise op2 is reg_b_i.
- R4: Opcode 7 (compare) and opcode 8 (compare by addition) hold wr_en_o low. They always update all four flags, from op1 - op2 and from op1 + op2 respectively.
- R5: For opcodes 0 to 6, when set_flags_i is 0, the output flags equal flags_i.
- R6: When flags are updated, N is the top bit of the result and Z is 1 exactly when the result is all zeros.
- R7: When an arithmetic operation updates flags, C is the carry out for additions and NOT borrow for subtractions (1 when the minuend is at least the subtrahend plus the borrow-in, compared as unsigned values). V is 1 on two's-complement overflow.
- R8: Opcodes 5 and 6 with set_flags_i high update only N and Z. C and V keep the values given by flags_i.
- R9: In status_o, N is bit 31, Z is bit 30, C is bit 29 and V is bit 28. Bits 27 to 0 are always 0. flags_i uses the same order at bits [3:0].
- R10: When op_valid_i is 0, or when the opcode is 9 to 15, wr_en_o is 0 and the output flags equal flags_i.
- R11: Outputs are registered with one cycle of latency. While rst_n is low, result_o, wr_en_o and status_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | An operation is issued this cycle |
| op_i | input | 4 | Opcode (0 to 8 defined) |
| set_flags_i | input | 1 | Request a flag update for opcodes 0 to 6 |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| reg_a_i | input | WIDTH | First operand |
| reg_b_i | input | WIDTH | Second operand, register source |
| imm_i | input | IMM_W | Immediate for the second operand |
| use_imm_i | input | 1 | Select the immediate as the second operand |
| result_o | output | WIDTH | Computed value, meaningful when wr_en_o is 1 |
| wr_en_o | output | 1 | Destination write enable |
| status_o | output | 32 | Status word with the flags in bits 31 to 28 |

## Verification
The assertions check on every cycle that the reserved status bits stay zero, that compares never assert a write, and that flags pass through unchanged when no update is requested or when the slot is idle. They also check that a flag-setting copy keeps C and V, and that N and Z follow the registered result. Only the bench's scenarios can show that the arithmetic itself is right. The bench sweeps every opcode against all operand pairs at a 4-bit width, both operand sources and several incoming flag patterns. This is what exposes wrong sums, a carry taken with the wrong polarity on subtraction, a mis-handled borrow-in, or a wrong signed overflow.

// File: rtl/alu_nzcv_pkg.sv
package alu_nzcv_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_RSB = 4'd4,
        OP_MOV = 4'd5,
        OP_MVN = 4'd6,
        OP_CMP = 4'd7,
        OP_CMN = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    localparam int STAT_W = 32;

    function automatic logic op_is_compare(input logic [3:0] op);
        return (op == OP_CMP) || (op == OP_CMN);
    endfunction

    function automatic logic op_is_move(input logic [3:0] op);
        return (op == OP_MOV) || (op == OP_MVN);
    endfunction

    function automatic logic op_is_arith(input logic [3:0] op);
        return (op <= OP_RSB) || op_is_compare(op);
    endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 12
) (
    input  logic [WIDTH-1:0] reg_b_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             use_imm_i,
    output logic [WIDTH-1:0] op2_o
);
    localparam int PAD_W = WIDTH - IMM_W;

    logic [WIDTH-1:0] imm_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign imm_ext = {{PAD_W{1'b0}}, imm_i};
        end else begin : g_trunc
            assign imm_ext = imm_i[WIDTH-1:0];
        end
    endgenerate

    assign op2_o = use_imm_i ? imm_ext : reg_b_i;

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_nzcv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] op1_i,
    input  logic [WIDTH-1:0] op2_i,
    input  logic             c_in_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] add_a, add_b;
    logic             add_cin;
    logic [WIDTH:0]   add_full;

    always_comb begin
        add_a   = op1_i;
        add_b   = op2_i;
        add_cin = 1'b0;
        case (op_i)
            OP_ADC: add_cin = c_in_i;
            OP_SUB, OP_CMP: begin
                add_b   = ~op2_i;
                add_cin = 1'b1;
            end
            OP_SBC: begin
                add_b   = ~op2_i;
                add_cin = c_in_i;
            end
            OP_RSB: begin
                add_a   = op2_i;
                add_b   = ~op1_i;
                add_cin = 1'b1;
            end
            default: ;
        endcase
        add_full = {1'b0, add_a} + {1'b0, add_b} + {{WIDTH{1'b0}}, add_cin};
    end

    assign sum_o   = add_full[WIDTH-1:0];
    assign carry_o = add_full[WIDTH];
    assign ovf_o   = (add_a[MSB] == add_b[MSB]) && (add_full[MSB] != add_a[MSB]);

endmodule

// File: rtl/alu_flag_next.sv
module alu_flag_next
    import alu_nzcv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op_i,
    input  logic             valid_i,
    input  logic             set_flags_i,
    input  nzcv_t            flags_i,
    input  logic [WIDTH-1:0] sum_i,
    input  logic             carry_i,
    input  logic             ovf_i,
    input  logic [WIDTH-1:0] op2_i,
    output logic [WIDTH-1:0] result_o,
    output logic             wr_en_o,
    output nzcv_t            flags_o
);
    logic is_cmp, is_mov, is_arith, upd;

    always_comb begin
        is_cmp   = op_is_compare(op_i);
        is_mov   = op_is_move(op_i);
        is_arith = op_is_arith(op_i);

        if (is_mov) begin
            result_o = (op_i == OP_MVN) ? ~op2_i : op2_i;
        end else begin
            result_o = sum_i;
        end

        wr_en_o = valid_i && ((is_arith && !is_cmp) || is_mov);
        upd     = valid_i && (is_cmp || (set_flags_i && (is_arith || is_mov)));

        flags_o = flags_i;
        if (upd) begin
            flags_o.n = result_o[WIDTH-1];
            flags_o.z = (result_o == '0);
            if (!is_mov) begin
                flags_o.c = carry_i;
                flags_o.v = ovf_i;
            end
        end
    end

endmodule

// File: rtl/alu_nzcv_top.sv
module alu_nzcv_top
    import alu_nzcv_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic [3:0]        op_i,
    input  logic              set_flags_i,
    input  logic [3:0]        flags_i,
    input  logic [WIDTH-1:0]  reg_a_i,
    input  logic [WIDTH-1:0]  reg_b_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_imm_i,
    output logic [WIDTH-1:0]  result_o,
    output logic              wr_en_o,
    output logic [STAT_W-1:0] status_o
);
    localparam int RSV_W = STAT_W - 4;

    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             wr_en;
        nzcv_t            flags;
    } alu_state_t;

    alu_state_t       state_d, state_q;
    logic [WIDTH-1:0] op2_w, sum_w, res_w;
    logic             carry_w, ovf_w, wr_w;
    nzcv_t            flags_in_w, flags_nx_w;

    assign flags_in_w = nzcv_t'(flags_i);

    alu_operand_sel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_opsel (
        .reg_b_i   (reg_b_i),
        .imm_i     (imm_i),
        .use_imm_i (use_imm_i),
        .op2_o     (op2_w)
    );

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .op_i    (op_i),
        .op1_i   (reg_a_i),
        .op2_i   (op2_w),
        .c_in_i  (flags_in_w.c),
        .sum_o   (sum_w),
        .carry_o (carry_w),
        .ovf_o   (ovf_w)
    );

    alu_flag_next #(.WIDTH(WIDTH)) u_flags (
        .op_i        (op_i),
        .valid_i     (op_valid_i),
        .set_flags_i (set_flags_i),
        .flags_i     (flags_in_w),
        .sum_i       (sum_w),
        .carry_i     (carry_w),
        .ovf_i       (ovf_w),
        .op2_i       (op2_w),
        .result_o    (res_w),
        .wr_en_o     (wr_w),
        .flags_o     (flags_nx_w)
    );

    always_comb begin
        state_d.result = res_w;
        state_d.wr_en  = wr_w;
        state_d.flags  = flags_nx_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.result;
    assign wr_en_o  = state_q.wr_en;
    assign status_o = {state_q.flags, {RSV_W{1'b0}}};

    // R4: compares never write a destination
    a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && (op_i == 4'd7 || op_i == 4'd8)) |=> !wr_en_o);

    // R5: non-compare ops without set-flags pass flags through
    a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !set_flags_i && op_i <= 4'd6) |=> (status_o[31:28] == $past(flags_i)));

    // R6: N and Z follow the registered result when flags are set
    a_r6_nz_track: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && set_flags_i && op_i <= 4'd6) |=>
        (status_o[31] == result_o[WIDTH-1]) && (status_o[30] == (result_o == '0)));

    // R8: flag-setting copies keep C and V
    a_r8_move_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && set_flags_i && (op_i == 4'd5 || op_i == 4'd6)) |=>
        (status_o[29:28] == $past(flags_i[1:0])));

    // R9: reserved status bits stay zero
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[27:0] == '0);

    // R10: idle slot or unused opcode writes nothing and keeps flags
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid_i || op_i > 4'd8) |=> (!wr_en_o && status_o[31:28] == $past(flags_i)));

endmodule

// File: tb/alu_nzcv_top_tb.sv
`timescale 1ns/1ps
module alu_nzcv_top_tb;
    localparam int W    = 4;
    localparam int IW   = 3;
    localparam int M    = (1 << W) - 1;
    localparam int HALF = 1 << (W - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid_i = 1'b0;
    logic [3:0]    op_i = '0;
    logic          set_flags_i = 1'b0;
    logic [3:0]    flags_i = '0;
    logic [W-1:0]  reg_a_i = '0;
    logic [W-1:0]  reg_b_i = '0;
    logic [IW-1:0] imm_i = '0;
    logic          use_imm_i = 1'b0;
    logic [W-1:0]  result_o;
    logic          wr_en_o;
    logic [31:0]   status_o;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    alu_nzcv_top #(.WIDTH(W), .IMM_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i),
        .set_flags_i(set_flags_i), .flags_i(flags_i), .reg_a_i(reg_a_i),
        .reg_b_i(reg_b_i), .imm_i(imm_i), .use_imm_i(use_imm_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .status_o(status_o)
    );

    function automatic int sx(input int x);
        return (x >= HALF) ? x - (M + 1) : x;
    endfunction

    function automatic bit sovf(input int s);
        return (s < -HALF) || (s > HALF - 1);
    endfunction

    task automatic check(input string tag, input logic exp_wr, input int exp_res,
                         input logic [3:0] exp_fl);
        logic [31:0] exp_st;
        exp_st = {exp_fl, 28'd0};
        n_checks++;
        if (wr_en_o !== exp_wr || status_o !== exp_st ||
            (exp_wr && result_o !== exp_res[W-1:0])) begin
            n_fail++;
            $display("FAIL %s: op=%0d a=%0d b=%0d wr=%0b/%0b res=%0d/%0d status=%h/%h",
                     tag, op_i, reg_a_i, reg_b_i, wr_en_o, exp_wr, result_o,
                     exp_res[W-1:0], status_o, exp_st);
        end
    endtask

    task automatic run_one(input int op, input int a, input int b, input int fl,
                           input bit sf, input bit imm, input bit valid);
        int   op2, r, sr, cin;
        logic c, v, wr, upd, mv, cmp;
        logic [3:0] ef;
        string tag;
        op2 = imm ? (b & ((1 << IW) - 1)) : b;
        op_valid_i = valid; op_i = op[3:0]; set_flags_i = sf; flags_i = fl[3:0];
        reg_a_i = a[W-1:0]; use_imm_i = imm;
        reg_b_i = imm ? W'(~b) : b[W-1:0];
        imm_i = b[IW-1:0];
        cin = fl[1] ? 1 : 0;
        r = 0; c = 1'b0; v = 1'b0; sr = 0;
        case (op)
            0, 8: begin r = a + op2; c = (r > M); sr = sx(a) + sx(op2); end
            1: begin r = a + op2 + cin; c = (r > M); sr = sx(a) + sx(op2) + cin; end
            2, 7: begin r = a - op2; c = (a >= op2); sr = sx(a) - sx(op2); end
            3: begin r = a - op2 - (1 - cin); c = (a >= op2 + 1 - cin);
                     sr = sx(a) - sx(op2) - (1 - cin); end
            4: begin r = op2 - a; c = (op2 >= a); sr = sx(op2) - sx(a); end
            5: r = op2;
            6: r = ~op2;
            default: r = 0;
        endcase
        r  = r & M;
        v  = sovf(sr);
        mv = (op == 5 || op == 6);
        cmp = (op == 7 || op == 8);
        wr = valid && (op <= 6);
        upd = valid && (cmp || (sf && op <= 6));
        ef = fl[3:0];
        if (upd) begin
            ef[3] = r[W-1];
            ef[2] = (r == 0);
            if (!mv) begin ef[1] = c; ef[0] = v; end
        end
        if (!valid || op > 8) tag = "R10 idle/unused";
        else if (cmp)         tag = "R4/R6/R7/R9 compare";
        else if (mv)          tag = sf ? "R3/R8 move-setflags" : "R3/R5 move";
        else if (op <= 1)     tag = sf ? "R1/R6/R7 add" : "R1/R5 add";
        else                  tag = sf ? "R2/R6/R7 sub" : "R2/R5 sub";
        @(posedge clk);
        #1;
        check(tag, wr, r, ef);
    endtask

    initial begin
        int pats[4];
        pats[0] = 4'b0000; pats[1] = 4'b0010; pats[2] = 4'b1101; pats[3] = 4'b1111;
        // R11: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset", 1'b0, 0, 4'b0000);
        rst_n = 1'b1;
        // R10: idle slots keep flags, no write
        for (int k = 0; k < 16; k++) run_one(k % 9, k, 15 - k, k, 1'b1, 1'b0, 1'b0);
        // Full sweep: every opcode, operand pair, flag pattern, set-flags, source
        for (int op = 0; op < 16; op++)
            for (int k = 0; k < 4; k++)
                for (int sf = 0; sf < 2; sf++)
                    for (int a = 0; a <= M; a++)
                        for (int b = 0; b <= M; b++)
                            run_one(op, a, b, pats[k], sf[0], k[0], 1'b1);
        // R11: reset clears registered outputs after activity
        run_one(1, 15, 15, 15, 1'b1, 1'b0, 1'b1);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R11 reset-after-use", 1'b0, 0, 4'b0000);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule